// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block samples a bank of general-purpose input pins and turns chosen signal transitions into latched interrupt events. Per pin, software picks detection on rising transitions, falling transitions, or both, by setting bits in two independent enable registers. Each detected transition sets a sticky bit in an event register. The bit stays set until software writes a one to that position.

The low group of pins (0 to 10) each drive a dedicated interrupt line. The high group (11 to 27) is OR-reduced into one shared line, and a handler finds the source by reading the event register. A separate per-pin wake mask decides which latched events drive the wake output.

Registers are reached through a plain synchronous read/write bus. Read data is registered, so it appears one cycle after the read strobe. Because this is a register port and not a data stream, there is no valid/ready handshake and no back-pressure: every strobe completes in the cycle it is sampled. Pin inputs are asynchronous and pass through a two-flop synchronizer.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every register reads 0, and `irq_direct`, `irq_shared` and `wake_out` are low.
- R2: With only the rising-enable bit set for a pin (register offset 0x0, bit n = pin n), a 0-to-1 transition sets that pin's event bit and a 1-to-0 transition does not.
- R3: With only the falling-enable bit set for a pin (offset 0x4, bit n = pin n), a 1-to-0 transition sets that pin's event bit and a 0-to-1 transition does not.
- R4: With both enable bits set, a transition in either direction sets the pin's event bit.
- R5: The event register (offset 0x8, bit n = pin n) is sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: If a clearing write and a new transition on the same pin land in the same cycle, the event bit ends up set.
- R7: Clearing both enable bits of a pin stops new events on that pin, and an event bit already latched stays set.
- R8: `irq_direct[n]` is high exactly when event bit n is set, for n = 0..10.
- R9: `irq_shared` is high exactly when any event bit in positions 11..27 is set. Events on pins 0..10 never drive it.
- R10: `wake_out` is high exactly when some pin has both its event bit and its wake-enable bit (offset 0xC, bit n = pin n) set.
- R11: Read data appears on `reg_rdata` one cycle after `reg_rd_en`. Bits 28..31 always read 0.
- R12: An event bit sets on the third rising clock edge after the pin changes (two synchronizer stages and one latch stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 28 | Asynchronous input pins |
| reg_wr_en | input | 1 | Write strobe |
| reg_rd_en | input | 1 | Read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_direct | output | 11 | One interrupt line per pin 0..10 |
| irq_shared | output | 1 | OR of events on pins 11..27 |
| wake_out | output | 1 | Wake request from wake-enabled events |

## Verification
The pin patterns separate the three detection modes from each other. Each direction is driven on a rising-only pin, a falling-only pin and a both-edges pin, so a swapped or merged enable shows up as a missing or extra event bit. Events are raised on both sides of the pin 10/11 boundary to tell the dedicated lines apart from the shared line. Wake is tested with an event whose pin is not wake-enabled and then with one whose pin is. A transition timed to meet a clearing write in the same cycle checks that the new event wins, and toggling a pin after its enables are cleared checks that no new event is latched while the old one is kept.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_RISE = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_FALL = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_WAKE = 4'hC;
endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_in,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] edge_hit
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pins_in[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign edge_hit[i] = (rise_en[i] & sync_q & ~prev_q) |
                         (fall_en[i] & ~sync_q & prev_q);
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_edge_pkg::*;
#(
  parameter int W      = 28,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      edge_hit,
  output logic [DATA_W-1:0] rdata,
  output logic [W-1:0]      rise_en,
  output logic [W-1:0]      fall_en,
  output logic [W-1:0]      wake_en,
  output logic [W-1:0]      status
);
  localparam int PAD = DATA_W - W;

  logic [W-1:0] clr_mask;
  logic [W-1:0] rd_sel;

  assign clr_mask = (wr_en && addr == OFS_STAT) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
      wake_en <= '0;
      status  <= '0;
    end else begin
      if (wr_en && addr == OFS_RISE) rise_en <= wdata;
      if (wr_en && addr == OFS_FALL) fall_en <= wdata;
      if (wr_en && addr == OFS_WAKE) wake_en <= wdata;
      // a fresh edge outranks a clear in the same cycle
      status <= (status & ~clr_mask) | edge_hit;
    end
  end

  always_comb begin
    unique case (addr)
      OFS_RISE: rd_sel = rise_en;
      OFS_FALL: rd_sel = fall_en;
      OFS_STAT: rd_sel = status;
      OFS_WAKE: rd_sel = wake_en;
      default:  rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= {{PAD{1'b0}}, rd_sel};
  end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
  parameter int W          = 28,
  parameter int NUM_DIRECT = 11
) (
  input  logic [W-1:0]          status,
  input  logic [W-1:0]          wake_en,
  output logic [NUM_DIRECT-1:0] irq_direct,
  output logic                  irq_shared,
  output logic                  wake_out
);
  localparam int NUM_SHARED = W - NUM_DIRECT;

  for (genvar i = 0; i < NUM_DIRECT; i++) begin : g_direct
    assign irq_direct[i] = status[i];
  end

  logic [NUM_SHARED-1:0] shared_bits;
  assign shared_bits = status[W-1:NUM_DIRECT];
  assign irq_shared  = |shared_bits;
  assign wake_out    = |(status & wake_en);
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int W          = 28,
  parameter int NUM_DIRECT = 11
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr_en,
  input logic [3:0]            reg_addr,
  input logic [W-1:0]          status_q,
  input logic [W-1:0]          rise_en_q,
  input logic [W-1:0]          fall_en_q,
  input logic [W-1:0]          wake_en_q,
  input logic [W-1:0]          edge_hit,
  input logic [NUM_DIRECT-1:0] irq_direct,
  input logic                  irq_shared,
  input logic                  wake_out
);
  logic stat_wr;
  assign stat_wr = reg_wr_en && reg_addr == 4'h8;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (status_q == '0 && !irq_shared && !wake_out));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_edge_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((status_q & $past(edge_hit)) == $past(edge_hit)));

  assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_en_q == '0 && fall_en_q == '0 && !stat_wr) |=> $stable(status_q));

  assert_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_direct == status_q[NUM_DIRECT-1:0]);

  assert_shared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shared == (status_q[W-1:NUM_DIRECT] != '0));

  assert_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_out == ((status_q & wake_en_q) != '0));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.W(NUM_PINS), .NUM_DIRECT(NUM_DIRECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .status_q(status_q), .rise_en_q(rise_en_q), .fall_en_q(fall_en_q),
  .wake_en_q(wake_en_q), .edge_hit(edge_hit), .irq_direct(irq_direct),
  .irq_shared(irq_shared), .wake_out(wake_out)
);

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS   = 28,
  parameter int NUM_DIRECT = 11,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic                  reg_wr_en,
  input  logic                  reg_rd_en,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic [NUM_DIRECT-1:0] irq_direct,
  output logic                  irq_shared,
  output logic                  wake_out
);
  logic [NUM_PINS-1:0] rise_en_q, fall_en_q, wake_en_q, status_q, edge_hit;
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_PINS];

  gpio_edge_detect #(.W(NUM_PINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .pins_in(pin_in),
    .rise_en(rise_en_q), .fall_en(fall_en_q), .edge_hit(edge_hit)
  );

  gpio_regfile #(.W(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata[NUM_PINS-1:0]), .edge_hit(edge_hit),
    .rdata(reg_rdata), .rise_en(rise_en_q), .fall_en(fall_en_q),
    .wake_en(wake_en_q), .status(status_q)
  );

  gpio_irq_route #(.W(NUM_PINS), .NUM_DIRECT(NUM_DIRECT)) u_route (
    .status(status_q), .wake_en(wake_en_q), .irq_direct(irq_direct),
    .irq_shared(irq_shared), .wake_out(wake_out)
  );
endmodule

// File: tb/tb_gpio_edge_irq.sv
`timescale 1ns/1ps
module tb_gpio_edge_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] pins = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [10:0] irq_direct;
  logic        irq_shared, wake_out;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { string req; logic [3:0] a; logic [31:0] exp; } rd_item_t;
  rd_item_t sb_q[$];

  always #4 clk = ~clk;

  gpio_edge_irq dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .reg_wr_en(wr_en),
    .reg_rd_en(rd_en), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq_direct(irq_direct), .irq_shared(irq_shared),
    .wake_out(wake_out)
  );

  // monitor: pops expected read results as the design produces them
  initial forever begin
    @(posedge clk);
    if (rd_en) begin
      #1;
      if (sb_q.size() == 0) begin
        failures++;
        $display("FAIL R11 unexpected read: actual %h expected none", rdata);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        checks++;
        if (rdata !== it.exp) begin
          failures++;
          $display("FAIL %s read @%h: actual %h expected %h", it.req, it.a, rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [31:0] e, input string req);
    rd_item_t it;
    it.req = req; it.a = a; it.exp = e;
    sb_q.push_back(it);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk); pins[p] = v;
    idle(5);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 irq_direct", {21'd0, irq_direct}, 32'd0);
    chk("R1 irq_shared", {31'd0, irq_shared}, 32'd0);
    chk("R1 wake_out", {31'd0, wake_out}, 32'd0);
    rd_expect(4'h0, 32'h0, "R1");
    rd_expect(4'h4, 32'h0, "R1");
    rd_expect(4'h8, 32'h0, "R1");
    rd_expect(4'hC, 32'h0, "R1");
    // R11 upper bits read zero
    wr(4'hC, 32'hFFFF_FFFF);
    rd_expect(4'hC, 32'h0FFF_FFFF, "R11");
    wr(4'hC, 32'h0);
    // pin0 rise, pin1 fall, pin2 both, pin12 both, pin20 rise
    wr(4'h0, 32'h0010_1005);
    wr(4'h4, 32'h0000_1006);
    rd_expect(4'h0, 32'h0010_1005, "R11");
    rd_expect(4'h4, 32'h0000_1006, "R11");

    // R12 latency: event bit absent after two edges, present after three
    @(negedge clk); pins[0] = 1'b1; pins[1] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R12 not yet", {21'd0, irq_direct}, 32'h0);
    @(negedge clk);
    chk("R12 latched", {21'd0, irq_direct}, 32'h1);
    idle(3);
    rd_expect(4'h8, 32'h0000_0001, "R2");
    chk("R8 direct", {21'd0, irq_direct}, 32'h1);
    chk("R9 shared low for pin0", {31'd0, irq_shared}, 32'd0);

    @(negedge clk); pins[0] = 1'b0; pins[1] = 1'b0;
    idle(5);
    rd_expect(4'h8, 32'h0000_0003, "R3");
    wr(4'h8, 32'h0000_0003);
    rd_expect(4'h8, 32'h0, "R5");

    // R4 both edges on pin2, R5 zero-write has no effect
    set_pin(2, 1'b1);
    rd_expect(4'h8, 32'h0000_0004, "R4");
    wr(4'h8, 32'h0);
    rd_expect(4'h8, 32'h0000_0004, "R5");
    wr(4'h8, 32'h0000_0004);
    set_pin(2, 1'b0);
    rd_expect(4'h8, 32'h0000_0004, "R4");
    chk("R8 direct pin2", {21'd0, irq_direct}, 32'h4);
    wr(4'h8, 32'h0000_0004);

    // R9 shared group
    set_pin(20, 1'b1);
    chk("R9 shared", {31'd0, irq_shared}, 32'd1);
    chk("R9 no direct", {21'd0, irq_direct}, 32'd0);
    wr(4'h8, 32'h0010_0000);
    idle(1);
    chk("R9 shared cleared", {31'd0, irq_shared}, 32'd0);

    // R10 wake qualification
    wr(4'hC, 32'h0010_0000);
    set_pin(12, 1'b1);
    rd_expect(4'h8, 32'h0000_1000, "R4");
    chk("R10 wake masked", {31'd0, wake_out}, 32'd0);
    chk("R9 shared pin12", {31'd0, irq_shared}, 32'd1);
    wr(4'hC, 32'h0010_1000);
    chk("R10 wake set", {31'd0, wake_out}, 32'd1);
    wr(4'h8, 32'h0000_1000);
    idle(1);
    chk("R10 wake cleared", {31'd0, wake_out}, 32'd0);

    // R7 disable pin12 with an event latched
    set_pin(12, 1'b0);
    rd_expect(4'h8, 32'h0000_1000, "R7");
    wr(4'h0, 32'h0010_0005);
    wr(4'h4, 32'h0000_0006);
    set_pin(12, 1'b1);
    rd_expect(4'h8, 32'h0000_1000, "R7");
    wr(4'h8, 32'h0000_1000);
    set_pin(12, 1'b0);
    rd_expect(4'h8, 32'h0, "R7");

    // R6 clear write lands on the same edge that latches a new event
    @(negedge clk); pins[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 4'h8; wdata = 32'h1;
    @(negedge clk); wr_en = 1'b0;
    idle(3);
    rd_expect(4'h8, 32'h0000_0001, "R6");
    chk("R6 direct", {21'd0, irq_direct}, 32'h1);

    idle(4);
    chk("scoreboard drained", sb_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule